// File: doc/BRIEF.md
# Capture/Reload Sixteen-Bit Timer

This block is a 16-bit timer/counter. Next to the live count it holds one 16-bit register pair that acts as the capture target or the reload source, depending on the mode. A single trigger pin can do three jobs, each under an enable: it can latch the count, reload it, or set the count direction. The count is advanced by an internal prescaled clock (system clock / 12), by the system clock / 2 when baud or clock-out generation is selected, or by falling edges on an external count pin.

Software sees six byte-wide registers through a write port and a combinational read port. Two sticky status flags report events: the overflow flag and the external-event flag. In baud-generation mode the block emits a one-cycle `baud_tick` pulse on each reload. A square-wave `clk_out` can be enabled, and it toggles on every overflow.

The operating mode is held in a state register with four states:
- ST_CAPTURE: capture on a trigger edge.
- ST_RELOAD: reload on overflow or on a trigger edge.
- ST_UPDOWN: the trigger pin sets the direction.
- ST_BAUD: divide-by-2 clock, reload on overflow only.

Every cycle the next state is decoded from the control bits, in this priority order:
1. Any baud select or the clock-out enable leads to ST_BAUD.
2. Otherwise the capture select leads to ST_CAPTURE.
3. Otherwise the down-count enable leads to ST_UPDOWN.
4. Otherwise the state is ST_RELOAD.

Any state may move to any other in one cycle.

Top module: `cr_timer16`

## Requirements
- R1: After reset every register reads 0 and `clk_out`, `baud_tick` are 0. The register addresses are: 0 control, 1 mode, 2 count low, 3 count high, 4 pair low, 5 pair high.
- R2: In ST_CAPTURE (control bit0 = 1) with the external enable set (control bit3), a falling trigger-pin edge copies the live count into the pair and sets the external flag (control bit6).
- R3: In ST_CAPTURE with the external enable clear, trigger edges change neither the pair nor the external flag. With the enable set, capture works even while the run bit is 0.
- R4: In ST_CAPTURE a count step at 16'hFFFF wraps to 0 and sets the overflow flag (control bit7).
- R5: In ST_RELOAD a count step at 16'hFFFF loads the pair value and sets the overflow flag.
- R6: In ST_RELOAD with the external enable set, a falling trigger edge loads the pair into the count and sets the external flag.
- R7: In ST_UPDOWN (mode bit0 = 1, no capture select), a trigger pin at 1 counts up, and overflow reloads from the pair. A trigger pin at 0 counts down. A step taken while the count equals the pair loads 16'hFFFF and sets the overflow flag.
- R8: Either baud select (control bit5 or bit4) overrides the capture select. The timer then steps every 2 system clocks and reloads from the pair only on overflow, without setting the overflow flag. It pulses `baud_tick` once per reload, so the period is 2*(65536-pair) clocks.
- R9: `clk_out` toggles on every overflow while the clock-out enable (mode bit1) is set. That enable also selects ST_BAUD timing. With the enable clear, `clk_out` never changes.
- R10: With the count-source bit (control bit1) set, the count steps once per falling edge of `cnt_pin`. Otherwise it steps once every 12 system clocks.
- R11: With the run bit (control bit2) clear, the count holds its value.
- R12: Both flags stay set until software writes the control register with that bit at 0.
- R13: Software writes to the count and pair bytes take effect and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| trig_pin | input | 1 | Trigger / direction pin (asynchronous) |
| cnt_pin | input | 1 | External count pin (asynchronous) |
| baud_tick | output | 1 | One-cycle pulse per reload in ST_BAUD |
| clk_out | output | 1 | Toggles on each overflow when enabled |

## Verification
If the state register decodes a wrong mode, the very next count step shows it at the ports. A capture mode would wrap to 0 where a reload mode loads the pair, and a baud mode would fail to raise the overflow flag, so a read of the count or control register one step later exposes it. A wrong direction or wrong underflow compare in ST_UPDOWN shows up as a count that misses 16'hFFFF on the step taken at the pair value. A wrong prescaler or reload shows up as a `baud_tick` or `clk_out` interval that differs from 2*(65536-pair) clocks on the first full period after the pair is written.

// File: rtl/crt_pkg.sv
package crt_pkg;
    typedef enum logic [1:0] {
        ST_CAPTURE = 2'd0,
        ST_RELOAD  = 2'd1,
        ST_UPDOWN  = 2'd2,
        ST_BAUD    = 2'd3
    } crt_state_e;

    // control register bit positions
    localparam int B_TF   = 7;
    localparam int B_EXF  = 6;
    localparam int B_RXB  = 5;
    localparam int B_TXB  = 4;
    localparam int B_EXEN = 3;
    localparam int B_RUN  = 2;
    localparam int B_CSEL = 1;
    localparam int B_CAP  = 0;

    // mode register bit positions
    localparam int M_CLKO = 1;
    localparam int M_DOWN = 0;
    localparam int MODE_W = 2;

    // register addresses
    localparam int A_CTRL   = 0;
    localparam int A_MODE   = 1;
    localparam int A_CNT_LO = 2;
    localparam int A_CNT_HI = 3;
    localparam int A_PR_LO  = 4;
    localparam int A_PR_HI  = 5;
endpackage

// File: rtl/crt_sync_edge.sv
module crt_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic lvl,
    output logic fall
);
    logic [STAGES-1:0] sh_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            prev_q <= 1'b0;
        end else begin
            sh_q   <= {sh_q[STAGES-2:0], pin};
            prev_q <= sh_q[STAGES-1];
        end
    end

    assign lvl  = sh_q[STAGES-1];
    assign fall = prev_q & ~sh_q[STAGES-1];
endmodule

// File: rtl/crt_tick_gen.sv
module crt_tick_gen #(
    parameter int SLOW_DIV = 12,
    parameter int FAST_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast,
    input  logic use_pin,
    input  logic pin_fall,
    output logic tick
);
    localparam int PW = $clog2(SLOW_DIV + 1);

    logic [PW-1:0] pre_q;
    logic [PW-1:0] lim;
    logic          pre_wrap;

    assign lim      = fast ? PW'(FAST_DIV - 1) : PW'(SLOW_DIV - 1);
    assign pre_wrap = (pre_q >= lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_wrap ? '0 : pre_q + 1'b1;
    end

    assign tick = use_pin ? pin_fall : pre_wrap;
endmodule

// File: rtl/crt_core.sv
module crt_core
    import crt_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  trig_lvl,
    input  logic                  trig_fall,
    input  logic                  cnt_tick,
    output crt_state_e            state_q,
    output logic [DATA_W-1:0]     ctrl_q,
    output logic [MODE_W-1:0]     mode_q,
    output logic [2*DATA_W-1:0]   count_q,
    output logic [2*DATA_W-1:0]   pair_q,
    output logic                  fast_sel,
    output logic                  pin_sel,
    output logic                  baud_tick,
    output logic                  clk_out
);
    localparam int CNT_W = 2 * DATA_W;

    crt_state_e          state_d;
    logic [CNT_W-1:0]    cnt_d, pair_d;
    logic [DATA_W-1:0]   ctrl_d;
    logic [MODE_W-1:0]   mode_d;
    logic                tf_set, exf_set, wrap;
    logic                step, ext_evt, at_top, at_floor;

    // next-state decode
    always_comb begin
        if (ctrl_q[B_RXB] || ctrl_q[B_TXB] || mode_q[M_CLKO]) state_d = ST_BAUD;
        else if (ctrl_q[B_CAP])                               state_d = ST_CAPTURE;
        else if (mode_q[M_DOWN])                              state_d = ST_UPDOWN;
        else                                                  state_d = ST_RELOAD;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CAPTURE;
        else        state_q <= state_d;
    end

    assign fast_sel = (state_q == ST_BAUD);
    assign pin_sel  = ctrl_q[B_CSEL] && !fast_sel;
    assign step     = ctrl_q[B_RUN] && cnt_tick;
    assign ext_evt  = ctrl_q[B_EXEN] && trig_fall;
    assign at_top   = (count_q == '1);
    assign at_floor = (count_q == pair_q);

    // per-state datapath
    always_comb begin
        cnt_d   = count_q;
        pair_d  = pair_q;
        tf_set  = 1'b0;
        exf_set = 1'b0;
        wrap    = 1'b0;
        unique case (state_q)
            ST_CAPTURE: begin
                if (step) begin
                    cnt_d  = count_q + 1'b1;
                    tf_set = at_top;
                    wrap   = at_top;
                end
                if (ext_evt) begin
                    pair_d  = count_q;
                    exf_set = 1'b1;
                end
            end
            ST_RELOAD: begin
                if (ext_evt) begin
                    cnt_d   = pair_q;
                    exf_set = 1'b1;
                end else if (step) begin
                    if (at_top) begin
                        cnt_d  = pair_q;
                        tf_set = 1'b1;
                        wrap   = 1'b1;
                    end else begin
                        cnt_d = count_q + 1'b1;
                    end
                end
            end
            ST_UPDOWN: begin
                if (step) begin
                    if (trig_lvl) begin
                        if (at_top) begin
                            cnt_d  = pair_q;
                            tf_set = 1'b1;
                            wrap   = 1'b1;
                        end else begin
                            cnt_d = count_q + 1'b1;
                        end
                    end else begin
                        if (at_floor) begin
                            cnt_d  = '1;
                            tf_set = 1'b1;
                            wrap   = 1'b1;
                        end else begin
                            cnt_d = count_q - 1'b1;
                        end
                    end
                end
            end
            ST_BAUD: begin
                if (step) begin
                    if (at_top) begin
                        cnt_d = pair_q;
                        wrap  = 1'b1;
                    end else begin
                        cnt_d = count_q + 1'b1;
                    end
                end
            end
        endcase

        ctrl_d        = ctrl_q;
        mode_d        = mode_q;
        if (wr_en) begin
            case (wr_addr)
                ADDR_W'(A_CTRL):   ctrl_d = wr_data;
                ADDR_W'(A_MODE):   mode_d = wr_data[MODE_W-1:0];
                ADDR_W'(A_CNT_LO): cnt_d[DATA_W-1:0]      = wr_data;
                ADDR_W'(A_CNT_HI): cnt_d[CNT_W-1:DATA_W]  = wr_data;
                ADDR_W'(A_PR_LO):  pair_d[DATA_W-1:0]     = wr_data;
                ADDR_W'(A_PR_HI):  pair_d[CNT_W-1:DATA_W] = wr_data;
                default: ;
            endcase
        end
        ctrl_d[B_TF]  = ctrl_d[B_TF]  | tf_set;
        ctrl_d[B_EXF] = ctrl_d[B_EXF] | exf_set;
    end

    // output / register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            mode_q    <= '0;
            count_q   <= '0;
            pair_q    <= '0;
            baud_tick <= 1'b0;
            clk_out   <= 1'b0;
        end else begin
            ctrl_q    <= ctrl_d;
            mode_q    <= mode_d;
            count_q   <= cnt_d;
            pair_q    <= pair_d;
            baud_tick <= wrap && (state_q == ST_BAUD);
            clk_out   <= clk_out ^ (wrap && mode_q[M_CLKO]);
        end
    end
endmodule

// File: rtl/cr_timer16.sv
module cr_timer16
    import crt_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 3,
    parameter int SLOW_DIV = 12,
    parameter int FAST_DIV = 2,
    parameter int STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              trig_pin,
    input  logic              cnt_pin,
    output logic              baud_tick,
    output logic              clk_out
);
    localparam int CNT_W  = 2 * DATA_W;
    localparam int N_PINS = 2;

    logic [N_PINS-1:0] pins, pin_lvl, pin_fall;
    logic              trig_lvl, trig_fall, cnt_fall, cnt_tick;
    logic              fast_sel, pin_sel;
    crt_state_e        state_q;
    logic [DATA_W-1:0] ctrl_q;
    logic [MODE_W-1:0] mode_q;
    logic [CNT_W-1:0]  count_q, pair_q;

    assign pins = {cnt_pin, trig_pin};

    for (genvar g = 0; g < N_PINS; g++) begin : g_sync
        crt_sync_edge #(.STAGES(STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (pins[g]),
            .lvl  (pin_lvl[g]),
            .fall (pin_fall[g])
        );
    end

    assign trig_lvl  = pin_lvl[0];
    assign trig_fall = pin_fall[0];
    assign cnt_fall  = pin_fall[1];
    wire   unused_cnt_lvl = pin_lvl[1];

    crt_tick_gen #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .fast    (fast_sel),
        .use_pin (pin_sel),
        .pin_fall(cnt_fall),
        .tick    (cnt_tick)
    );

    crt_core #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .trig_lvl (trig_lvl),
        .trig_fall(trig_fall),
        .cnt_tick (cnt_tick),
        .state_q  (state_q),
        .ctrl_q   (ctrl_q),
        .mode_q   (mode_q),
        .count_q  (count_q),
        .pair_q   (pair_q),
        .fast_sel (fast_sel),
        .pin_sel  (pin_sel),
        .baud_tick(baud_tick),
        .clk_out  (clk_out)
    );

    always_comb begin
        case (rd_addr)
            ADDR_W'(A_CTRL):   rd_data = ctrl_q;
            ADDR_W'(A_MODE):   rd_data = DATA_W'(mode_q);
            ADDR_W'(A_CNT_LO): rd_data = count_q[DATA_W-1:0];
            ADDR_W'(A_CNT_HI): rd_data = count_q[CNT_W-1:DATA_W];
            ADDR_W'(A_PR_LO):  rd_data = pair_q[DATA_W-1:0];
            ADDR_W'(A_PR_HI):  rd_data = pair_q[CNT_W-1:DATA_W];
            default:           rd_data = '0;
        endcase
    end
endmodule

// File: rtl/cr_timer16_chk.sv
module cr_timer16_chk
    import crt_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   wr_addr,
    input crt_state_e          state_q,
    input logic [DATA_W-1:0]   ctrl_q,
    input logic [MODE_W-1:0]   mode_q,
    input logic [2*DATA_W-1:0] count_q,
    input logic [2*DATA_W-1:0] pair_q,
    input logic                trig_lvl,
    input logic                trig_fall,
    input logic                cnt_tick,
    input logic                clk_out
);
    logic ctrl_wr;
    assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(A_CTRL));

    AST_CAPTURE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CAPTURE && ctrl_q[B_EXEN] && trig_fall && !wr_en)
        |=> (pair_q == $past(count_q)) && ctrl_q[B_EXF]); // R2

    AST_DOWN_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UPDOWN && ctrl_q[B_RUN] && cnt_tick && !trig_lvl
         && count_q == pair_q && !wr_en)
        |=> (count_q == '1) && ctrl_q[B_TF]); // R7

    AST_BAUD_NO_TF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BAUD && !ctrl_q[B_TF] && !wr_en) |=> !ctrl_q[B_TF]); // R8

    AST_CLKOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q[M_CLKO] |=> $stable(clk_out)); // R9

    AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[B_RUN] && !wr_en && !trig_fall) |=> $stable(count_q)); // R11

    AST_TF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[B_TF] && !ctrl_wr) |=> ctrl_q[B_TF]); // R12

    AST_EXF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[B_EXF] && !ctrl_wr) |=> ctrl_q[B_EXF]); // R12
endmodule

bind cr_timer16 cr_timer16_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .state_q  (state_q),
    .ctrl_q   (ctrl_q),
    .mode_q   (mode_q),
    .count_q  (count_q),
    .pair_q   (pair_q),
    .trig_lvl (trig_lvl),
    .trig_fall(trig_fall),
    .cnt_tick (cnt_tick),
    .clk_out  (clk_out)
);

// File: tb/sim_cr_timer16.sv
`timescale 1ns/1ps
module sim_cr_timer16;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       trig_pin = 1'b1;
    logic       cnt_pin = 1'b0;
    logic       baud_tick, clk_out;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cr_timer16 u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .trig_pin(trig_pin), .cnt_pin(cnt_pin),
        .baud_tick(baud_tick), .clk_out(clk_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr16(input int lo_a, input int v);
        wr(lo_a, v & 8'hFF);
        wr(lo_a + 1, (v >> 8) & 8'hFF);
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        rd_addr = 3'(a);
        #1 d = int'(rd_data);
    endtask

    task automatic rd16(input int lo_a, output int v);
        int lo, hi;
        rd(lo_a, lo);
        rd(lo_a + 1, hi);
        v = (hi << 8) | lo;
    endtask

    task automatic pulse_cnt();
        @(negedge clk) cnt_pin = 1'b1;
        repeat (4) @(negedge clk);
        cnt_pin = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic trig_edge();
        @(negedge clk) trig_pin = 1'b0;
        repeat (4) @(negedge clk);
        trig_pin = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_baud(output int t);
        int guard = 0;
        do begin @(negedge clk); guard++; end while (!baud_tick && guard < 2000);
        t = cyc;
    endtask

    task automatic wait_clko(output int t);
        int guard = 0;
        logic v;
        v = clk_out;
        do begin @(negedge clk); guard++; end while (clk_out == v && guard < 2000);
        t = cyc;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        int v, m, t0, t1;
        int rl [4];
        rl[0] = 16'h0000; rl[1] = 16'h1234; rl[2] = 16'hFFFE; rl[3] = 16'h8000;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(a, v); chk("R1 reg reset", v, 0);
        end
        chk("R1 clk_out reset", int'(clk_out), 0);
        chk("R1 baud_tick reset", int'(baud_tick), 0);

        // R13 software writes
        wr16(2, 16'h1234); rd16(2, v); chk("R13 count write", v, 16'h1234);
        wr16(4, 16'hABCD); rd16(4, v); chk("R13 pair write", v, 16'hABCD);

        // R10 external count sweep (reload mode, run, pin source)
        wr(0, 8'h06);
        wr16(2, 16'h0100);
        for (int k = 1; k <= 8; k++) begin
            pulse_cnt();
            rd16(2, v); chk("R10 pin count", v, 16'h0100 + k);
        end

        // R11 run clear holds count
        wr(0, 8'h02);
        repeat (3) pulse_cnt();
        rd16(2, v); chk("R11 hold", v, 16'h0108);

        // R4 capture-mode overflow, R12 sticky
        wr(0, 8'h07);
        wr16(2, 16'hFFFE);
        pulse_cnt(); pulse_cnt();
        rd16(2, v); chk("R4 wrap to zero", v, 0);
        rd(0, v); chk("R4 TF set", (v >> 7) & 1, 1);
        pulse_cnt();
        rd(0, v); chk("R12 TF sticky", (v >> 7) & 1, 1);
        wr(0, 8'h07);
        rd(0, v); chk("R12 TF cleared", (v >> 7) & 1, 0);

        // R2 capture on trigger edge
        wr(0, 8'h0F);
        wr16(2, 16'h0040);
        repeat (5) pulse_cnt();
        trig_edge();
        rd16(4, v); chk("R2 captured", v, 16'h0045);
        rd(0, v); chk("R2 EXF set", (v >> 6) & 1, 1);
        rd16(2, v); chk("R2 count kept", v, 16'h0045);

        // R3 no capture without enable; capture while stopped
        wr(0, 8'h03);
        wr16(2, 16'h0077);
        trig_edge();
        rd16(4, v); chk("R3 pair unchanged", v, 16'h0045);
        rd(0, v); chk("R3 EXF clear", (v >> 6) & 1, 0);
        wr(0, 8'h0B);
        trig_edge();
        rd16(4, v); chk("R3 capture while stopped", v, 16'h0077);
        pulse_cnt(); pulse_cnt();
        rd16(2, v); chk("R11 stopped in capture", v, 16'h0077);

        // R5 reload on overflow sweep
        for (int i = 0; i < 4; i++) begin
            wr(0, 8'h06);
            wr16(4, rl[i]);
            wr16(2, 16'hFFFD);
            repeat (3) pulse_cnt();
            rd16(2, v); chk("R5 reload value", v, rl[i]);
            rd(0, v); chk("R5 TF set", (v >> 7) & 1, 1);
        end

        // R6 reload on trigger edge
        wr(0, 8'h0E);
        wr16(4, 16'h2000);
        wr16(2, 16'h0005);
        trig_edge();
        rd16(2, v); chk("R6 edge reload", v, 16'h2000);
        rd(0, v); chk("R6 EXF set", (v >> 6) & 1, 1);
        chk("R6 TF untouched", (v >> 7) & 1, 0);

        // R7 down count with underflow
        wr(1, 8'h01);
        wr(0, 8'h06);
        wr16(4, 16'h0010);
        wr16(2, 16'h0012);
        @(negedge clk) trig_pin = 1'b0;
        repeat (4) @(negedge clk);
        m = 16'h0012;
        for (int k = 0; k < 5; k++) begin
            pulse_cnt();
            m = (m == 16'h0010) ? 16'hFFFF : m - 1;
            rd16(2, v); chk("R7 down step", v, m);
        end
        rd(0, v); chk("R7 underflow TF", (v >> 7) & 1, 1);
        @(negedge clk) trig_pin = 1'b1;
        repeat (4) @(negedge clk);
        wr(0, 8'h06);
        wr16(2, 16'hFFFE);
        pulse_cnt();
        rd16(2, v); chk("R7 up step", v, 16'hFFFF);
        pulse_cnt();
        rd16(2, v); chk("R7 up overflow reload", v, 16'h0010);
        rd(0, v); chk("R7 up TF", (v >> 7) & 1, 1);

        // R8 baud period sweep; capture select set but ignored
        wr(1, 8'h00);
        wr(0, 8'h15);
        for (int r = 16'hFFFF; r >= 16'hFFF0; r--) begin
            wr16(4, r);
            wr16(2, r);
            wait_baud(t0);
            wait_baud(t0);
            @(negedge clk);
            wait_baud(t1);
            chk("R8 baud period", t1 - t0, 2 * (65536 - r));
        end
        rd(0, v); chk("R8 no TF in baud", (v >> 7) & 1, 0);
        chk("R9 clk_out quiet when disabled", int'(clk_out), 0);
        wr(0, 8'h00);

        // R9 clock-out toggling
        wr(1, 8'h02);
        wr16(4, 16'hFFFC);
        wr16(2, 16'hFFFC);
        wr(0, 8'h04);
        wait_clko(t0);
        wait_clko(t0);
        wait_clko(t1);
        chk("R9 toggle interval", t1 - t0, 8);
        wr(0, 8'h00);
        wr(1, 8'h00);

        // R10 internal prescaler: one step per 12 clocks
        wr16(4, 0);
        wr16(2, 0);
        wr(0, 8'h04);
        repeat (120) @(negedge clk);
        wr(0, 8'h00);
        rd16(2, v);
        chk("R10 prescaled rate", int'(v >= 9 && v <= 11), 1);

        finish_run();
    end
endmodule